// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block divides a 32.768 kHz tick enable down to a programmable periodic event. A 4-bit rate code picks an interval that is a power of two of ticks. On every event the block emits a one-clock event strobe. It also emits a status-flag set mask, which is present only when periodic interrupts are enabled, and a one-clock square-wave pulse, which is present only when the square-wave output is enabled. A status register outside the block ORs the flag mask into its interrupt-request and periodic bits.

The divider is a free-running tick counter. An event fires whenever the incremented count is an exact multiple of the period. The counter advances only while the rate code is nonzero and at least one of the two enables is set. Otherwise the counter is held at zero, so every restart begins a full period from a clean count. A new rate code is picked up at the end of the period in progress, so the pulse stream never carries a shortened or stretched half-step from a mid-period write.

Top module: `pit_rate_gen`

## Requirements
- R1: After synchronous reset, `evt_strobe`, `sqw_pulse` and `irq_flags` are all zero.
- R2: With `rate_code` equal to 0, or with both `pie_en` and `sqw_en` low, no event occurs and the tick counter is cleared. After re-enabling, the first event comes a full period of ticks later.
- R3: For a code c from 3 to 15 the event interval is 2^(c-1) ticks (code 3 gives 4 ticks, code 15 gives 16384 ticks).
- R4: Code 1 gives a 128-tick interval and code 2 gives a 256-tick interval. These are the intervals of codes 8 and 9.
- R5: Counting from a cleared counter, the first event lands on exactly one period of ticks, and each later event lands on the next multiple of the period.
- R6: During an event strobe, `irq_flags` equals 8'hC0 (bit 7 interrupt request, bit 6 periodic) when `pie_en` is set and 0 otherwise. Outside a strobe, `irq_flags` is 0.
- R7: `sqw_pulse` is high for exactly the one clock of an event strobe when `sqw_en` is set, and it is never high otherwise. `evt_strobe` fires on every event while the divider runs.
- R8: A change of `rate_code` while running takes effect only after the period in progress completes. For example, 8-tick running, then change to code 3, gives one more 8-tick gap and then 4-tick gaps.
- R9: An event occurs only on a clock where `tick_en` is high. Its strobe is high for one clock, the clock after that tick's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock enable at the 32.768 kHz tick rate |
| rate_code | input | 4 | Rate select code, 0 disables |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| evt_strobe | output | 1 | One-clock periodic event strobe |
| irq_flags | output | 8 | Status flag set mask during an event |
| sqw_pulse | output | 1 | One-clock square-wave pulse |

## Verification
The hardest case to reach is a rate change that lands inside a running period. The old interval has to finish before the new one starts, and that only shows if the write falls strictly between two events. The bench waits for one event, writes a faster code on the next clock, and then measures the next two gaps in ticks. It expects one old-length gap followed by a new-length gap. The slowest code needs 16384 ticks, so ticks are issued every other clock, and only the first event is timed from a cleared counter.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        RC_OFF    = 2'd0,
        RC_ALIAS  = 2'd1,
        RC_DIRECT = 2'd2
    } rate_class_e;

    typedef struct packed {
        logic strobe;
        logic irq;
        logic sqw;
    } pit_evt_t;

    // Classify a rate code: zero stops, the two lowest nonzero codes alias.
    function automatic rate_class_e classify(input int unsigned code);
        if (code == 0)
            return RC_OFF;
        else if (code <= 2)
            return RC_ALIAS;
        else
            return RC_DIRECT;
    endfunction

    // Exponent of the period (period = 2**exp ticks).
    function automatic int unsigned period_exp(input int unsigned code,
                                               input int unsigned alias_base);
        case (classify(code))
            RC_ALIAS:  return alias_base + code - 2;
            RC_DIRECT: return code - 1;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
    import pit_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 14,
    parameter int ALIAS_BASE = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  mask,
    output logic              off
);
    localparam int EXP_W = $clog2(CNT_W + 1);

    logic [EXP_W-1:0] exp_v;
    logic [CNT_W:0]   mask_wide;
    int unsigned      exp_raw;

    always_comb begin
        exp_raw = period_exp(int'(code), ALIAS_BASE);
        if (exp_raw > CNT_W)
            exp_raw = CNT_W;
        exp_v     = EXP_W'(exp_raw);
        mask_wide = ((CNT_W + 1)'(1) << exp_v) - (CNT_W + 1)'(1);
        mask      = mask_wide[CNT_W-1:0];
        off       = (classify(int'(code)) == RC_OFF);
    end

endmodule

// File: rtl/pit_divider.sv
module pit_divider #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] next_mask,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask_q;
    logic             valid_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] eff_mask;

    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign eff_mask = valid_q ? mask_q : next_mask;
    assign hit      = run && tick && ((cnt_inc & eff_mask) == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            mask_q  <= '1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b1;
            if (!valid_q || hit)
                mask_q <= next_mask;
            if (tick)
                cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/pit_event_out.sv
module pit_event_out
    import pit_pkg::*;
#(
    parameter int              FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] FLAG_MASK = 8'hC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              pie_en,
    input  logic              sqw_en,
    output logic              evt_strobe,
    output logic [FLAG_W-1:0] irq_flags,
    output logic              sqw_pulse
);
    pit_evt_t evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.strobe <= hit;
            evt_q.irq    <= hit && pie_en;
            evt_q.sqw    <= hit && sqw_en;
        end
    end

    assign evt_strobe = evt_q.strobe;
    assign irq_flags  = evt_q.irq ? FLAG_MASK : '0;
    assign sqw_pulse  = evt_q.sqw;

endmodule

// File: rtl/pit_rate_gen.sv
module pit_rate_gen
    import pit_pkg::*;
#(
    parameter int                CODE_W     = 4,
    parameter int                ALIAS_BASE = 8,
    parameter int                FLAG_W     = 8,
    parameter logic [FLAG_W-1:0] FLAG_MASK  = 8'hC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqw_en,
    output logic              evt_strobe,
    output logic [FLAG_W-1:0] irq_flags,
    output logic              sqw_pulse
);
    localparam int CNT_W = (1 << CODE_W) - 2;

    logic [CNT_W-1:0] next_mask;
    logic             code_off;
    logic             run;
    logic             hit;

    assign run = (pie_en || sqw_en) && !code_off;

    pit_rate_decode #(
        .CODE_W    (CODE_W),
        .CNT_W     (CNT_W),
        .ALIAS_BASE(ALIAS_BASE)
    ) u_decode (
        .code(rate_code),
        .mask(next_mask),
        .off (code_off)
    );

    pit_divider #(
        .CNT_W(CNT_W)
    ) u_divider (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick_en),
        .next_mask(next_mask),
        .hit      (hit)
    );

    pit_event_out #(
        .FLAG_W   (FLAG_W),
        .FLAG_MASK(FLAG_MASK)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .evt_strobe(evt_strobe),
        .irq_flags (irq_flags),
        .sqw_pulse (sqw_pulse)
    );

endmodule

// File: rtl/pit_rate_gen_chk.sv
module pit_rate_gen_chk #(
    parameter int                CODE_W    = 4,
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] FLAG_MASK = 8'hC0
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [CODE_W-1:0] rate_code,
    input logic              pie_en,
    input logic              sqw_en,
    input logic              evt_strobe,
    input logic [FLAG_W-1:0] irq_flags,
    input logic              sqw_pulse
);
    // R2: stopped divider produces no event
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!(pie_en || sqw_en) || rate_code == '0) |=> !evt_strobe);

    // R9: events only follow a tick
    a_r9_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> !evt_strobe);

    // R9: strobe lasts one clock
    a_r9_one_clock: assert property (@(posedge clk) disable iff (rst)
        evt_strobe |=> !evt_strobe);

    // R6: flag mask only inside a strobe, and only the fixed value
    a_r6_flag_value: assert property (@(posedge clk) disable iff (rst)
        irq_flags != '0 |-> (irq_flags == FLAG_MASK && evt_strobe));

    // R6: flags need the periodic enable
    a_r6_pie_gates: assert property (@(posedge clk) disable iff (rst)
        !pie_en |=> irq_flags == '0);

    // R7: square-wave pulse only inside a strobe and only when enabled
    a_r7_sqw_in_strobe: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse |-> evt_strobe);

    a_r7_sqw_gated: assert property (@(posedge clk) disable iff (rst)
        !sqw_en |=> !sqw_pulse);

endmodule

bind pit_rate_gen pit_rate_gen_chk #(
    .CODE_W   (CODE_W),
    .FLAG_W   (FLAG_W),
    .FLAG_MASK(FLAG_MASK)
) u_chk (.*);

// File: tb/pit_rate_gen_bench.sv
`timescale 1ns/1ps
module pit_rate_gen_bench;
    localparam int TDIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       evt_strobe;
    logic [7:0] irq_flags;
    logic       sqw_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // monitor state
    bit   tick_run = 1'b0;
    int   div = 0;
    int   ticks = 0;
    int   ev_count = 0;
    int   ev_tick [16];
    logic [7:0] flags_seen = 8'h00;
    logic sqw_seen = 1'b0;
    int   stray = 0;
    bit   prev_strobe = 1'b0;

    always #2 clk = ~clk;

    pit_rate_gen u_pit_rate_gen (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .evt_strobe(evt_strobe),
        .irq_flags (irq_flags),
        .sqw_pulse (sqw_pulse)
    );

    // Observe outputs and drive the tick enable, both on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (evt_strobe) begin
                if (prev_strobe) stray++;
                ev_count++;
                ev_tick[ev_count & 15] = ticks;
                flags_seen = irq_flags;
                sqw_seen   = sqw_pulse;
            end else if (irq_flags != 8'h00 || sqw_pulse) begin
                stray++;
            end
            prev_strobe = evt_strobe;
        end
        if (tick_run && div == TDIV - 1) begin
            tick_en = 1'b1;
            ticks++;
            div = 0;
        end else begin
            tick_en = 1'b0;
            if (tick_run) div++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_events(input int target, input int limit);
        int guard = 0;
        while (ev_count < target && guard < limit) begin
            @(negedge clk);
            #1;
            guard++;
        end
    endtask

    // Quiesce, set the mode, then start ticks from a cleared counter.
    task automatic start_mode(input logic [3:0] code, input logic pie,
                              input logic sqw, output int base, output int e0);
        tick_run = 1'b0;
        settle(4);
        pie_en = 1'b0;
        sqw_en = 1'b0;
        settle(3);
        rate_code = code;
        pie_en = pie;
        sqw_en = sqw;
        settle(3);
        base = ticks;
        e0 = ev_count;
        tick_run = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 strobe after reset", int'(evt_strobe), 0);
        chk("R1 flags after reset", int'(irq_flags), 0);
        chk("R1 sqw after reset", int'(sqw_pulse), 0);
    endtask

    task automatic t_rate(input logic [3:0] code, input logic pie, input logic sqw,
                          input int period, input int n_ev, input string req);
        int base, e0;
        start_mode(code, pie, sqw, base, e0);
        wait_events(e0 + n_ev, period * TDIV * (n_ev + 1) + 100);
        chk({req, " event count"}, ev_count - e0, n_ev);
        chk({"R5 first event ", req}, ev_tick[(e0 + 1) & 15] - base, period);
        for (int k = 2; k <= n_ev; k++)
            chk({req, " gap"}, ev_tick[(e0 + k) & 15] - ev_tick[(e0 + k - 1) & 15], period);
        chk({"R6 flags ", req}, int'(flags_seen), pie ? 32'hC0 : 0);
        chk({"R7 sqw ", req}, int'(sqw_seen), int'(sqw));
        tick_run = 1'b0;
    endtask

    task automatic t_idle();
        int base, e0;
        start_mode(4'd0, 1'b1, 1'b1, base, e0);
        settle(600);
        chk("R2 code zero no events", ev_count - e0, 0);
        start_mode(4'd5, 1'b0, 1'b0, base, e0);
        settle(600);
        chk("R2 enables low no events", ev_count - e0, 0);
        tick_run = 1'b0;
    endtask

    task automatic t_restart();
        int base, e0;
        start_mode(4'd5, 1'b1, 1'b0, base, e0);
        wait_events(e0 + 1, 200);
        settle(5 * TDIV);
        tick_run = 1'b0;
        settle(3);
        pie_en = 1'b0;
        settle(3);
        pie_en = 1'b1;
        settle(3);
        base = ticks;
        e0 = ev_count;
        tick_run = 1'b1;
        wait_events(e0 + 1, 200);
        chk("R2 restart full period", ev_tick[(e0 + 1) & 15] - base, 16);
        tick_run = 1'b0;
    endtask

    task automatic t_change();
        int base, e0;
        start_mode(4'd4, 1'b1, 1'b0, base, e0);
        wait_events(e0 + 1, 200);
        @(negedge clk);
        rate_code = 4'd3;
        wait_events(e0 + 3, 200);
        chk("R8 old period completes", ev_tick[(e0 + 2) & 15] - ev_tick[(e0 + 1) & 15], 8);
        chk("R8 new period applies", ev_tick[(e0 + 3) & 15] - ev_tick[(e0 + 2) & 15], 4);
        tick_run = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        settle(2);
        t_reset();
        t_rate(4'd3, 1'b1, 1'b0, 4, 4, "R3 code3");
        t_rate(4'd6, 1'b0, 1'b1, 32, 3, "R3 code6");
        t_rate(4'd9, 1'b1, 1'b1, 256, 2, "R3 code9");
        t_rate(4'd1, 1'b1, 1'b0, 128, 3, "R4 code1");
        t_rate(4'd2, 1'b0, 1'b1, 256, 2, "R4 code2");
        t_rate(4'd15, 1'b1, 1'b0, 16384, 1, "R3 code15");
        t_idle();
        t_restart();
        t_change();
        chk("R9 R7 R6 no stray or stretched pulses", stray, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule